// File: doc/BRIEF.md
# Prioritised Chip-Select Address Decoder

This block decides which of a fixed set of chip-select banks owns a transaction address. Each bank holds a base value, a per-bit compare mask, a valid flag and an attribute word made of a port-size code and a machine-type code. When the request strobe is high, the upper part of the address is checked against every bank at the same time. The checks that pass are reduced to one winner by a fixed priority.

The result is registered. One clock after the strobe the block presents a one-hot bank select, a hit flag and its complement, the index of the winning bank, and that bank's attribute word. The access sequencer that follows uses these outputs. Banks are programmed through a write port that loads one complete bank entry per clock.

Top module: `cs_bank_decoder`

## Requirements
- R1: After reset every bank is invalid, and dec_vld, dec_hit, dec_nohit and dec_sel are all zero.
- R2: Only the CMP_W (default 19) most significant bits of req_addr take part in the comparison. The lower bits never change the result.
- R3: A bank matches when (addr_hi & mask) equals (base & mask). A mask bit of 1 compares that address bit and a mask bit of 0 ignores it, so an all-zero mask matches every address.
- R4: A bank whose valid bit is 0 never matches, whatever its base and mask.
- R5: When several banks match, only the lowest-numbered one is selected, so dec_sel is one-hot or zero.
- R6: The decode of a request sampled at a clock edge appears on the outputs right after that edge, with dec_vld high. After an edge with req low, dec_vld, dec_hit, dec_nohit and dec_sel are zero.
- R7: When a request matches no bank, dec_nohit is 1, dec_hit is 0, and dec_sel, dec_idx, dec_psize and dec_mtype are all zero.
- R8: On a hit, dec_idx is the binary number of the winning bank, dec_sel has only that bit set, and dec_psize and dec_mtype are that bank's stored fields.
- R9: A bank write takes effect at the edge on which it is sampled. A request sampled on the same edge is decoded with the previous settings.
- R10: A write changes only the bank named by cfg_bank. Every other bank keeps its settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Bank entry write strobe |
| cfg_bank | input | 3 | Bank written |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_base | input | 19 | Base value for the upper address bits |
| cfg_mask | input | 19 | Compare mask, 1 = bit compared |
| cfg_psize | input | 2 | Port-size code to store |
| cfg_mtype | input | 2 | Machine-type code to store |
| req | input | 1 | Request strobe |
| req_addr | input | 32 | Transaction address |
| dec_vld | output | 1 | Decode result valid |
| dec_hit | output | 1 | Some bank matched |
| dec_nohit | output | 1 | No bank matched |
| dec_sel | output | 8 | One-hot winning bank |
| dec_idx | output | 3 | Winning bank number |
| dec_psize | output | 2 | Winning bank port size |
| dec_mtype | output | 2 | Winning bank machine type |

## Verification
A corrupted base, mask or valid bit in a bank shows up only when a request touches the region that bank covers or ought to cover. It then gives a wrong dec_sel, dec_idx or attribute one clock after that strobe. A fault in the priority chain stays hidden until two banks overlap, so overlapping regions are programmed on purpose. They are placed at both ends of the bank range and next to an all-zero mask. A write that lands in the wrong bank is exposed by sweeping requests across every programmed region after each write.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  typedef enum logic [1:0] {
    MT_GENERIC = 2'd0,
    MT_SYNC    = 2'd1,
    MT_PROGRAM = 2'd2,
    MT_SPARE   = 2'd3
  } mtype_e;

  typedef struct packed {
    logic [1:0] psize;
    mtype_e     mtype;
  } bank_attr_t;

  localparam bank_attr_t ATTR_ZERO = '{psize: 2'd0, mtype: MT_GENERIC};

endpackage

// File: rtl/cs_bank_store.sv
module cs_bank_store
  import cs_dec_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int CMP_W = 19,
  localparam int IDX_W = $clog2(NBANK)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_bank,
  input  logic                         wr_valid,
  input  logic [CMP_W-1:0]             wr_base,
  input  logic [CMP_W-1:0]             wr_mask,
  input  bank_attr_t                   wr_attr,
  output logic [NBANK-1:0]             valid_q,
  output logic [NBANK-1:0][CMP_W-1:0]  base_q,
  output logic [NBANK-1:0][CMP_W-1:0]  mask_q,
  output bank_attr_t [NBANK-1:0]       attr_q
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             ld;
    logic             valid_d;
    logic [CMP_W-1:0] base_d;
    logic [CMP_W-1:0] mask_d;
    bank_attr_t       attr_d;

    always_comb begin
      ld      = wr_en && (wr_bank == IDX_W'(b));
      valid_d = valid_q[b];
      base_d  = base_q[b];
      mask_d  = mask_q[b];
      attr_d  = attr_q[b];
      if (ld) begin
        valid_d = wr_valid;
        base_d  = wr_base;
        mask_d  = wr_mask;
        attr_d  = wr_attr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[b] <= 1'b0;
        base_q[b]  <= '0;
        mask_q[b]  <= '0;
        attr_q[b]  <= ATTR_ZERO;
      end else begin
        valid_q[b] <= valid_d;
        base_q[b]  <= base_d;
        mask_q[b]  <= mask_d;
        attr_q[b]  <= attr_d;
      end
    end

    // R10: a bank not addressed by the write keeps its entry
    p_other_bank_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_bank == IDX_W'(b)) |=>
        ($stable(valid_q[b]) && $stable(base_q[b]) && $stable(mask_q[b]) && $stable(attr_q[b])));
  end

endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match #(
  parameter int NBANK = 8,
  parameter int CMP_W = 19
) (
  input  logic [CMP_W-1:0]             addr_hi,
  input  logic [NBANK-1:0]             valid,
  input  logic [NBANK-1:0][CMP_W-1:0]  base,
  input  logic [NBANK-1:0][CMP_W-1:0]  mask,
  output logic [NBANK-1:0]             hit
);

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    logic [CMP_W-1:0] diff;
    always_comb begin
      diff   = (addr_hi ^ base[b]) & mask[b];
      hit[b] = valid[b] && (diff == '0);
    end
  end

endmodule

// File: rtl/cs_low_prio.sv
module cs_low_prio #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     reqv,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | reqv[i];
    assign grant[i]  = reqv[i] & ~seen[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = seen[N];

  // R5: at most one grant, and only to a requesting bank
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~reqv) == '0));

  // R5: some grant whenever any bank requests
  p_grant_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqv != '0) |-> ($countones(grant) == 1));

endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import cs_dec_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 19,
  localparam int IDX_W = $clog2(NBANK),
  localparam int LSB   = ADDR_W - CMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_bank,
  input  logic              cfg_valid,
  input  logic [CMP_W-1:0]  cfg_base,
  input  logic [CMP_W-1:0]  cfg_mask,
  input  logic [1:0]        cfg_psize,
  input  logic [1:0]        cfg_mtype,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dec_vld,
  output logic              dec_hit,
  output logic              dec_nohit,
  output logic [NBANK-1:0]  dec_sel,
  output logic [IDX_W-1:0]  dec_idx,
  output logic [1:0]        dec_psize,
  output logic [1:0]        dec_mtype
);

  logic [NBANK-1:0]            valid_q;
  logic [NBANK-1:0][CMP_W-1:0] base_q;
  logic [NBANK-1:0][CMP_W-1:0] mask_q;
  bank_attr_t [NBANK-1:0]      attr_q;
  bank_attr_t                  wr_attr;
  logic [CMP_W-1:0]            addr_hi;
  logic                        unused_low_bits;
  logic [NBANK-1:0]            hit_vec;
  logic [NBANK-1:0]            grant;
  logic [IDX_W-1:0]            win_idx;
  logic                        any_hit;

  assign wr_attr         = '{psize: cfg_psize, mtype: mtype_e'(cfg_mtype)};
  assign addr_hi         = req_addr[ADDR_W-1:LSB];
  assign unused_low_bits = ^req_addr[LSB-1:0];

  cs_bank_store #(.NBANK(NBANK), .CMP_W(CMP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_bank  (cfg_bank),
    .wr_valid (cfg_valid),
    .wr_base  (cfg_base),
    .wr_mask  (cfg_mask),
    .wr_attr  (wr_attr),
    .valid_q  (valid_q),
    .base_q   (base_q),
    .mask_q   (mask_q),
    .attr_q   (attr_q)
  );

  cs_bank_match #(.NBANK(NBANK), .CMP_W(CMP_W)) u_match (
    .addr_hi (addr_hi),
    .valid   (valid_q),
    .base    (base_q),
    .mask    (mask_q),
    .hit     (hit_vec)
  );

  cs_low_prio #(.N(NBANK)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .reqv  (hit_vec),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_hit)
  );

  // next-state for the result register
  logic             vld_d;
  logic             hit_d;
  logic             nohit_d;
  logic [NBANK-1:0] sel_d;
  logic [IDX_W-1:0] idx_d;
  bank_attr_t       attr_d;
  logic             res_en;

  always_comb begin
    res_en  = req;
    vld_d   = req;
    hit_d   = req && any_hit;
    nohit_d = req && !any_hit;
    sel_d   = req ? grant : '0;
    idx_d   = any_hit ? win_idx : '0;
    attr_d  = any_hit ? attr_q[win_idx] : ATTR_ZERO;
  end

  bank_attr_t attr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld   <= 1'b0;
      dec_hit   <= 1'b0;
      dec_nohit <= 1'b0;
      dec_sel   <= '0;
    end else begin
      dec_vld   <= vld_d;
      dec_hit   <= hit_d;
      dec_nohit <= nohit_d;
      dec_sel   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_idx <= '0;
      attr_r  <= ATTR_ZERO;
    end else if (res_en) begin
      dec_idx <= idx_d;
      attr_r  <= attr_d;
    end
  end

  assign dec_psize = attr_r.psize;
  assign dec_mtype = attr_r.mtype;

  // R6: a result follows every sampled request, and only then
  p_vld_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> dec_vld);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!dec_vld && !dec_hit && !dec_nohit && dec_sel == '0));

  // R7: exactly one of hit / no-hit on a valid result; no-hit carries zeros
  p_hit_xor_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> (dec_hit != dec_nohit));
  p_nohit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_nohit |-> (dec_sel == '0 && dec_idx == '0 && dec_psize == '0 && dec_mtype == '0));

  // R8: select and index name the same bank
  p_sel_idx_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> ($onehot(dec_sel) && dec_sel[dec_idx]));

  // R4: a matched bank was valid when the request was sampled
  p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ((dec_sel & ~$past(valid_q)) == '0));

endmodule

// File: tb/test_cs_bank_decoder.sv
module test_cs_bank_decoder;
  localparam int NB = 8;
  localparam int AW = 32;
  localparam int CW = 19;
  localparam int LSB = AW - CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_bank;
  logic          cfg_valid;
  logic [CW-1:0] cfg_base;
  logic [CW-1:0] cfg_mask;
  logic [1:0]    cfg_psize;
  logic [1:0]    cfg_mtype;
  logic          req;
  logic [AW-1:0] req_addr;
  logic          dec_vld, dec_hit, dec_nohit;
  logic [NB-1:0] dec_sel;
  logic [2:0]    dec_idx;
  logic [1:0]    dec_psize, dec_mtype;

  always #2 clk = ~clk;

  cs_bank_decoder i_cs_bank_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_psize(cfg_psize), .cfg_mtype(cfg_mtype), .req(req), .req_addr(req_addr),
    .dec_vld(dec_vld), .dec_hit(dec_hit), .dec_nohit(dec_nohit), .dec_sel(dec_sel),
    .dec_idx(dec_idx), .dec_psize(dec_psize), .dec_mtype(dec_mtype)
  );

  int checks = 0;
  int errors = 0;

  logic          m_valid [NB];
  logic [CW-1:0] m_base  [NB];
  logic [CW-1:0] m_mask  [NB];
  logic [1:0]    m_ps    [NB];
  logic [1:0]    m_mt    [NB];

  // expected decode packed as {hit, nohit, sel, idx, psize, mtype}
  function automatic logic [17:0] ref_dec(input logic [AW-1:0] a);
    logic [CW-1:0] hi;
    hi = a[AW-1:LSB];
    for (int b = 0; b < NB; b++) begin
      if (m_valid[b] && ((hi & m_mask[b]) == (m_base[b] & m_mask[b])))
        return {1'b1, 1'b0, 8'(1 << b), 3'(b), m_ps[b], m_mt[b]};
    end
    return {1'b0, 1'b1, 8'd0, 3'd0, 2'd0, 2'd0};
  endfunction

  function automatic logic [17:0] got();
    return {dec_hit, dec_nohit, dec_sel, dec_idx, dec_psize, dec_mtype};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input int b, input logic v, input logic [CW-1:0] bs,
                             input logic [CW-1:0] mk, input logic [1:0] ps, input logic [1:0] mt);
    m_valid[b] = v; m_base[b] = bs; m_mask[b] = mk; m_ps[b] = ps; m_mt[b] = mt;
  endtask

  task automatic wr(input int b, input logic v, input logic [CW-1:0] bs,
                    input logic [CW-1:0] mk, input logic [1:0] ps, input logic [1:0] mt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 3'(b); cfg_valid = v; cfg_base = bs;
    cfg_mask = mk; cfg_psize = ps; cfg_mtype = mt;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(b, v, bs, mk, ps, mt);
  endtask

  task automatic rq(input string tag, input logic [AW-1:0] a);
    logic [17:0] e;
    @(negedge clk);
    req = 1'b1; req_addr = a;
    e = ref_dec(a);
    @(negedge clk);
    req = 1'b0;
    check(tag, {dec_vld, got()}, {1'b1, e});
  endtask

  function automatic logic [AW-1:0] addr_in(input int b);
    logic [CW-1:0] hi;
    hi = (m_base[b] & m_mask[b]) | (CW'($urandom) & ~m_mask[b]);
    return {hi, LSB'($urandom)};
  endfunction

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; cfg_we = 0; cfg_bank = 0; cfg_valid = 0; cfg_base = 0;
    cfg_mask = 0; cfg_psize = 0; cfg_mtype = 0; req = 0; req_addr = 0;
    for (int b = 0; b < NB; b++) model_write(b, 1'b0, '0, '0, 2'd0, 2'd0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {dec_vld, dec_hit, dec_nohit, dec_sel, 8'd0}, 19'd0);
    rst_n = 1'b1;
    // R1: invalid banks (all-zero mask) do not match after reset
    rq("R1 R4 fresh no-hit", 32'h1234_5678);

    // R4: all-zero mask but invalid never matches
    wr(3, 1'b0, 19'h0, 19'h0, 2'd1, 2'd2);
    rq("R4 invalid bank", 32'hdead_beef);
    // R3: all-zero mask matches everything once valid
    wr(3, 1'b1, 19'h0, 19'h0, 2'd1, 2'd2);
    rq("R3 zero mask", 32'hdead_beef);
    // R5: bank 1 overlaps with bank 3, lower wins
    wr(1, 1'b1, 19'h12345, 19'h7ff00, 2'd3, 2'd1);
    rq("R5 overlap low wins", {19'h12399, 13'h0});
    rq("R5 R8 fallthrough", {19'h55555, 13'h1fff});
    // R2: low bits never matter
    wr(3, 1'b0, 19'h0, 19'h0, 2'd0, 2'd0);
    wr(7, 1'b1, 19'h7ffff, 19'h7ffff, 2'd2, 2'd3);
    rq("R2 low zeros", {19'h7ffff, 13'h0000});
    rq("R2 low ones", {19'h7ffff, 13'h1fff});
    rq("R3 one bit off", {19'h7fffe, 13'h1fff});
    // R6: idle cycle after request clears the outputs
    @(negedge clk);
    check("R6 idle", {dec_vld, dec_hit, dec_nohit, dec_sel, 8'd0}, 19'd0);
    // R10: write bank 0 leaves bank 7 intact
    wr(0, 1'b1, 19'h00001, 19'h7ffff, 2'd1, 2'd1);
    rq("R10 bank7 kept", {19'h7ffff, 13'h0042});
    rq("R8 bank0", {19'h00001, 13'h0042});
    // R9: write and request on the same edge use old settings
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 3'd0; cfg_valid = 1'b1; cfg_base = 19'h7ffff;
    cfg_mask = 19'h7ffff; cfg_psize = 2'd0; cfg_mtype = 2'd2;
    req = 1'b1; req_addr = {19'h00001, 13'h0};
    begin
      logic [17:0] e;
      e = ref_dec(req_addr);
      @(negedge clk);
      cfg_we = 1'b0; req = 1'b0;
      check("R9 same edge old", {dec_vld, got()}, {1'b1, e});
    end
    model_write(0, 1'b1, 19'h7ffff, 19'h7ffff, 2'd0, 2'd2);
    rq("R9 next edge new", {19'h7ffff, 13'h0});

    // random configurations and requests
    for (int round = 0; round < 40; round++) begin
      for (int b = 0; b < NB; b++) begin
        logic [CW-1:0] mk;
        int k;
        k = $urandom_range(0, CW);
        mk = ($urandom_range(0, 3) == 0) ? CW'($urandom) : ~CW'((1 << k) - 1);
        wr(b, ($urandom_range(0, 4) != 0), CW'($urandom), mk,
           2'($urandom), 2'($urandom));
      end
      for (int n = 0; n < 30; n++) begin
        if ($urandom_range(0, 3) == 0) rq("R3 R5 R7 random addr", $urandom);
        else rq("R2 R3 R5 R8 random hit", addr_in($urandom_range(0, NB - 1)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule